// File: doc/BRIEF.md
# Six-Phase 8-bit Register-Bus Processor

This block is a small multi-cycle processor with an 8-bit datapath and an 8-bit address space. It holds three general registers (X, Y, Z), a program counter and a zero flag. Every instruction is two bytes: an opcode followed by an address byte. The address byte is always fetched, whether or not the instruction uses it. A single memory port carries the instruction fetches and the data accesses.

Every instruction runs through the same six phases of a sequencer, one phase per clock:

- `PH_FETCH_OP`: the PC drives the address and the opcode is captured.
- `PH_STEP_OP`: the PC steps.
- `PH_FETCH_AD`: the PC drives the address and the address byte is captured.
- `PH_STEP_AD`: the PC steps.
- `PH_EXEC`: a read or write goes to the captured address, or the ALU result and the zero flag are captured.
- `PH_WBACK`: the target register is written.

The transitions are fixed. Reset enters `PH_FETCH_OP`. Each phase moves to the next in the order above, and `PH_WBACK` returns to `PH_FETCH_OP`. A jump is a load into the PC. The only branch is a load that takes effect while the zero flag is set.

The memory port reads combinationally: `mem_rdata` must reflect `mem_addr` in the same cycle. A write happens at the clock edge that ends a cycle in which `mem_we` is high.

Top module: `cpu8_core`

## Requirements
- R1: While reset is low and in the first cycle after it, the block drives `mem_addr` = 0 and `mem_we` = 0. Reset clears PC, X, Y, Z and the zero flag to 0, and execution starts at address 0.
- R2: Each instruction takes exactly six cycles. The opcode is read from PC in the first cycle and the address byte from PC+1 in the third. A store drives `mem_we` for exactly one cycle, the fifth.
- R3: Opcode bits [7:6] = 00 form a load. It copies mem[addr] into the target that bits [1:0] select: 0 X, 1 Y, 2 Z, 3 PC. A load into the PC is an absolute jump.
- R4: Bits [7:6] = 01 form a conditional load with the same target coding. It acts as a load only when the zero flag is 1. Otherwise the only effect is that the PC moves past the instruction.
- R5: Bits [7:6] = 10 form a store. It writes the register selected by bits [1:0] to mem[addr]. A stored PC equals the address of the next instruction.
- R6: Bits [7:6] = 11 form a math operation. Bits [2:0] select the operation: 0 AND, 1 OR, 2 XOR, 3 ADD, 4 SUB. SUB computes X minus Y. The result, modulo 256, goes to Z.
- R7: The zero flag is 1 exactly when the last math result was 0. Loads, conditional loads and stores leave it unchanged.
- R8: Some opcodes are undefined: bits [5:2] nonzero for classes 00, 01 and 10, and for class 11 either bits [5:3] nonzero or bits [2:0] above 4. An undefined opcode is a six-cycle no-op. It changes no register and no memory location, and the PC still advances by two.
- R9: The PC wraps modulo 256. An instruction at address 0xFE leaves a following PC of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Data to write |
| mem_rdata | input | 8 | Data read from `mem_addr`, combinational |
| mem_we | output | 1 | Write enable |

## Verification
Eight math vectors run one fixed program.

- Each opcode gets at least one vector, and AND, ADD and SUB get one zero and one nonzero result. This separates the operand order, the operation choice and the zero flag.
- An add that carries out to exactly zero and a subtract that borrows check the modulo-256 behaviour.
- The conditional load in the same program takes the opposite path depending on the flag. This exposes any polarity error.

Directed programs cover the remaining cases:

- Phase timing, observed at the port.
- Undefined opcodes that sit next to valid ones.
- A flag that must survive intervening loads.
- A conditional jump.
- A PC that wraps past 0xFF.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    typedef enum logic [2:0] {
        PH_FETCH_OP = 3'd0,
        PH_STEP_OP  = 3'd1,
        PH_FETCH_AD = 3'd2,
        PH_STEP_AD  = 3'd3,
        PH_EXEC     = 3'd4,
        PH_WBACK    = 3'd5
    } phase_t;

    typedef enum logic [1:0] {
        CL_LOAD  = 2'd0,
        CL_CLOAD = 2'd1,
        CL_SAVE  = 2'd2,
        CL_MATH  = 2'd3
    } cls_t;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4
    } aluop_t;

    localparam int unsigned NUM_GPR = 3;
    localparam int unsigned SEL_W   = 2;
    localparam logic [SEL_W-1:0] SEL_Z  = 2'd2;
    localparam logic [SEL_W-1:0] SEL_PC = 2'd3;

    typedef struct packed {
        logic             valid;
        cls_t             cls;
        logic [SEL_W-1:0] sel;
        aluop_t           op;
    } dec_t;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [7:0] ir,
    output dec_t       dec
);
    always_comb begin
        dec.cls = cls_t'(ir[7:6]);
        dec.sel = ir[SEL_W-1:0];
        dec.op  = aluop_t'(ir[2:0]);
        if (ir[7:6] == 2'b11) begin
            dec.valid = (ir[5:3] == 3'b000) && (ir[2:0] <= 3'd4);
        end else begin
            dec.valid = (ir[5:2] == 4'b0000);
        end
    end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  aluop_t         op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           is_zero
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            default: y = '0;
        endcase
        is_zero = (y == '0);
    end
endmodule

// File: rtl/cpu8_seq.sv
module cpu8_seq
    import cpu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dec_valid,
    input  cls_t   dec_cls,
    input  logic   zf,
    output phase_t phase,
    output logic   ir_ld,
    output logic   ar_ld,
    output logic   pc_inc,
    output logic   addr_from_ar,
    output logic   mem_we,
    output logic   mdr_ld,
    output logic   res_ld,
    output logic   wb_en
);
    phase_t phase_nx;

    always_comb begin
        unique case (phase)
            PH_FETCH_OP: phase_nx = PH_STEP_OP;
            PH_STEP_OP:  phase_nx = PH_FETCH_AD;
            PH_FETCH_AD: phase_nx = PH_STEP_AD;
            PH_STEP_AD:  phase_nx = PH_EXEC;
            PH_EXEC:     phase_nx = PH_WBACK;
            PH_WBACK:    phase_nx = PH_FETCH_OP;
            default:     phase_nx = PH_FETCH_OP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH_OP;
        else        phase <= phase_nx;
    end

    always_comb begin
        ir_ld        = 1'b0;
        ar_ld        = 1'b0;
        pc_inc       = 1'b0;
        addr_from_ar = 1'b0;
        mem_we       = 1'b0;
        mdr_ld       = 1'b0;
        res_ld       = 1'b0;
        wb_en        = 1'b0;
        unique case (phase)
            PH_FETCH_OP: ir_ld  = rst_n;
            PH_STEP_OP:  pc_inc = 1'b1;
            PH_FETCH_AD: ar_ld  = 1'b1;
            PH_STEP_AD:  pc_inc = 1'b1;
            PH_EXEC: begin
                addr_from_ar = 1'b1;
                if (dec_valid) begin
                    unique case (dec_cls)
                        CL_LOAD, CL_CLOAD: mdr_ld = 1'b1;
                        CL_SAVE:           mem_we = 1'b1;
                        CL_MATH:           res_ld = 1'b1;
                        default:           ;
                    endcase
                end
            end
            PH_WBACK: begin
                if (dec_valid) begin
                    unique case (dec_cls)
                        CL_LOAD:  wb_en = 1'b1;
                        CL_CLOAD: wb_en = zf;
                        CL_MATH:  wb_en = 1'b1;
                        default:  wb_en = 1'b0;
                    endcase
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu8_regs.sv
module cpu8_regs
    import cpu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_en,
    input  logic [SEL_W-1:0] wb_sel,
    input  logic [W-1:0]     wb_data,
    input  logic             pc_inc,
    input  logic             flag_ld,
    input  logic             flag_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     pc,
    output logic             zf
);
    logic [W-1:0] gpr [NUM_GPR];

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)                                  gpr[g] <= '0;
            else if (wb_en && wb_sel == SEL_W'(g))       gpr[g] <= wb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        pc <= '0;
        else if (wb_en && wb_sel == SEL_PC) pc <= wb_data;
        else if (pc_inc)                   pc <= pc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       zf <= 1'b0;
        else if (flag_ld) zf <= flag_val;
    end

    always_comb begin
        if (rd_sel == SEL_PC) rd_data = pc;
        else                  rd_data = gpr[rd_sel];
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_we
);
    logic [7:0]   ir_q;
    logic [W-1:0] ar_q, mdr_q, res_q;
    dec_t         dec;
    phase_t       phase;
    logic         ir_ld, ar_ld, pc_inc, addr_from_ar, mdr_ld, res_ld, wb_en;
    logic [W-1:0] pc_q, rd_data, gx, gy, alu_y, wb_data;
    logic         alu_zero, zf_q;
    logic [SEL_W-1:0] wb_sel;
    logic         dec_valid;
    cls_t         dec_cls;

    assign dec_valid = dec.valid;
    assign dec_cls   = dec.cls;

    cpu8_decode u_dec (.ir(ir_q), .dec(dec));

    cpu8_seq u_seq (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec.valid), .dec_cls(dec.cls),
        .zf(zf_q), .phase(phase), .ir_ld(ir_ld), .ar_ld(ar_ld),
        .pc_inc(pc_inc), .addr_from_ar(addr_from_ar), .mem_we(mem_we),
        .mdr_ld(mdr_ld), .res_ld(res_ld), .wb_en(wb_en)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            ar_q  <= '0;
            mdr_q <= '0;
            res_q <= '0;
        end else begin
            if (ir_ld)  ir_q  <= mem_rdata[7:0];
            if (ar_ld)  ar_q  <= mem_rdata;
            if (mdr_ld) mdr_q <= mem_rdata;
            if (res_ld) res_q <= alu_y;
        end
    end

    assign wb_sel  = (dec.cls == CL_MATH) ? SEL_Z : dec.sel;
    assign wb_data = (dec.cls == CL_MATH) ? res_q : mdr_q;

    cpu8_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_data(wb_data), .pc_inc(pc_inc), .flag_ld(res_ld),
        .flag_val(alu_zero), .rd_sel(dec.sel), .rd_data(rd_data),
        .pc(pc_q), .zf(zf_q)
    );

    assign gx = u_regs.gpr[0];
    assign gy = u_regs.gpr[1];

    cpu8_alu #(.W(W)) u_alu (
        .op(dec.op), .a(gx), .b(gy), .y(alu_y), .is_zero(alu_zero)
    );

    assign mem_addr  = addr_from_ar ? ar_q : pc_q;
    assign mem_wdata = rd_data;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
    import cpu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input phase_t       phase,
    input logic [W-1:0] pc,
    input logic         zf,
    input logic         dec_valid,
    input cls_t         dec_cls,
    input logic [W-1:0] res,
    input logic [W-1:0] zreg,
    input logic [W-1:0] mem_addr,
    input logic         mem_we
);
    // R1
    reset_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase == PH_FETCH_OP && pc == '0 && !mem_we));

    // R2
    we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> phase == PH_EXEC);

    // R2
    seq_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_WBACK |=> phase == PH_FETCH_OP);

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH_OP || phase == PH_FETCH_AD) |-> mem_addr == pc);

    // R6
    math_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WBACK && dec_valid && dec_cls == CL_MATH) |=> zreg == $past(res));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase == PH_EXEC && dec_valid && dec_cls == CL_MATH) |=> $stable(zf));

    // R9
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEP_OP && pc == {W{1'b1}}) |=> pc == '0);
endmodule

bind cpu8_core cpu8_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .pc(pc_q), .zf(zf_q),
    .dec_valid(dec_valid), .dec_cls(dec_cls), .res(res_q),
    .zreg(u_regs.gpr[2]), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/sim_cpu8_core.sv
module sim_cpu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we;
    logic [7:0] mem [256];
    int         checks = 0;
    int         errors = 0;
    int         wr_cnt = 0;
    int         cyc = 0;

    always #2 clk = ~clk;

    cpu8_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles, expected under 50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // {opcode, x, y, expected z, expected zero flag}
    localparam logic [39:0] VECS [8] = '{
        {8'hC0, 8'hF0, 8'h3C, 8'h30, 8'h00},
        {8'hC0, 8'h0F, 8'hF0, 8'h00, 8'h01},
        {8'hC1, 8'h12, 8'h21, 8'h33, 8'h00},
        {8'hC2, 8'hA5, 8'hA5, 8'h00, 8'h01},
        {8'hC3, 8'h7F, 8'h01, 8'h80, 8'h00},
        {8'hC3, 8'hFF, 8'h01, 8'h00, 8'h01},
        {8'hC4, 8'h10, 8'h20, 8'hF0, 8'h00},
        {8'hC4, 8'h44, 8'h44, 8'h00, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic enter_reset();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wr_cnt = 0;
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] op, input logic [7:0] ad);
        mem[a]      = op;
        mem[a + 8'd1] = ad;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // reset state
        enter_reset();
        @(negedge clk);
        check("R1 addr in reset", mem_addr, 8'h00);
        check("R1 we in reset", {7'd0, mem_we}, 8'h00);

        // math vectors
        for (int v = 0; v < 8; v++) begin
            enter_reset();
            put(8'h00, 8'h00, 8'hF0);
            put(8'h02, 8'h01, 8'hF1);
            put(8'h04, VECS[v][39:32], 8'h00);
            put(8'h06, 8'h82, 8'hF2);
            put(8'h08, 8'h40, 8'hF3);
            put(8'h0A, 8'h80, 8'hF4);
            put(8'h0C, 8'h03, 8'hF5);
            mem[8'hF0] = VECS[v][31:24];
            mem[8'hF1] = VECS[v][23:16];
            mem[8'hF2] = 8'hEE;
            mem[8'hF3] = 8'h5A;
            mem[8'hF5] = 8'h0C;
            run(70);
            check($sformatf("R6 vec %0d Z", v), mem[8'hF2], VECS[v][15:8]);
            check($sformatf("R4 R7 vec %0d cond load", v), mem[8'hF4],
                  VECS[v][0] ? 8'h5A : VECS[v][31:24]);
            check($sformatf("R5 vec %0d write count", v), 8'(wr_cnt), 8'd2);
        end

        // R2 phase timing at the port
        enter_reset();
        put(8'h00, 8'h83, 8'hF6);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 first fetch addr", mem_addr, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 address byte fetch", mem_addr, 8'h01);
        @(posedge clk); @(negedge clk);
        check("R2 no write before exec", {7'd0, mem_we}, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R2 write in fifth cycle", {7'd0, mem_we}, 8'h01);
        check("R2 write addr", mem_addr, 8'hF6);
        check("R5 stored PC", mem_wdata, 8'h02);
        @(posedge clk); @(negedge clk);
        check("R2 write one cycle", {7'd0, mem_we}, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R2 next fetch after six", mem_addr, 8'h02);

        // R8 undefined opcodes
        enter_reset();
        put(8'h00, 8'h00, 8'hF0);
        put(8'h02, 8'h3C, 8'hF1);
        put(8'h04, 8'hC7, 8'h00);
        put(8'h06, 8'h80, 8'hF8);
        put(8'h08, 8'h82, 8'hF9);
        put(8'h0A, 8'h83, 8'hFA);
        put(8'h0C, 8'h03, 8'hFB);
        mem[8'hF0] = 8'h77; mem[8'hF1] = 8'h11; mem[8'hF9] = 8'hEE; mem[8'hFB] = 8'h0C;
        run(90);
        check("R8 X untouched", mem[8'hF8], 8'h77);
        check("R8 Z untouched", mem[8'hF9], 8'h00);
        check("R8 PC advanced", mem[8'hFA], 8'h0C);
        check("R8 memory untouched", mem[8'hF1], 8'h11);
        check("R8 write count", 8'(wr_cnt), 8'd3);

        // R7 flag survives loads, R4 conditional jump, R3 load targets
        enter_reset();
        put(8'h00, 8'hC4, 8'h00);
        put(8'h02, 8'h00, 8'hF0);
        put(8'h04, 8'h41, 8'hF1);
        put(8'h06, 8'h81, 8'hF2);
        put(8'h08, 8'h43, 8'hF3);
        put(8'h0A, 8'h80, 8'hF6);
        put(8'h20, 8'h80, 8'hF4);
        put(8'h22, 8'h03, 8'hF5);
        mem[8'hF0] = 8'h07; mem[8'hF1] = 8'h09; mem[8'hF3] = 8'h20; mem[8'hF5] = 8'h22;
        run(90);
        check("R7 flag kept over load", mem[8'hF2], 8'h09);
        check("R3 load X", mem[8'hF4], 8'h07);
        check("R4 conditional jump taken", mem[8'hF6], 8'h00);

        // R9 PC wrap
        enter_reset();
        put(8'h00, 8'h03, 8'h10);
        put(8'hFE, 8'h83, 8'hF7);
        mem[8'h10] = 8'hFE; mem[8'hF7] = 8'h55;
        run(14);
        check("R9 PC wraps", mem[8'hF7], 8'h00);
        check("R3 jump via load", 8'(wr_cnt), 8'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule